// File: doc/BRIEF.md
# Universal Bus Transceiver Data Path

This block models a configurable data path that joins two ports, A and B, through two channels that work independently: one carries A toward B, the other carries B toward A. Each channel has four controls of its own: an active-low clock enable, a latch enable, a channel clock and an active-low output enable. Together they select one of three ways of passing data. In transparent mode the output follows the input. In latch mode the output freezes on the falling edge of the latch enable. In register mode the output loads on a rising edge of the channel clock, and those edges can be inhibited. Each channel has a single storage register, which all three modes share.

A free-running system clock samples every control and data input. Channel-clock rising edges and latch-enable falling edges are found by comparing successive samples, so the block needs no second clock domain. Each port is split into an input vector, an output vector and an output-enable vector. An all-zero enable vector stands for high impedance. A flag reports when both channels drive at the same time. The flag only reports the case and does not resolve it.

Top module: `ubt_datapath`

## Requirements
- R1: A synchronous active-high reset clears both storage registers to zero and returns both output-enable vectors to all zeros. After reset, with the latch enable low, an enabled output reads zero whatever its input.
- R2: If a channel's active-low output enable is sampled high, its output-enable vector is all zeros. If it is sampled low, the vector is all ones. The change appears INPUT_STAGES system clocks after the pin changes, whatever the other controls are doing.
- R3: While the latch enable is high, the channel output equals its input, delayed by INPUT_STAGES system clocks. Clock enable and channel clock have no effect in this state.
- R4: When the latch enable falls, the output keeps the last input sampled while the latch enable was high. Later input changes do not alter the output, and neither does a channel clock held at a static level.
- R5: With clock enable low and latch enable low, a rising channel-clock edge loads the input sampled with that edge. The output shows the value INPUT_STAGES+1 system clocks after the edge.
- R6: With clock enable high and latch enable low, rising channel-clock edges are inhibited and the output keeps its previous value.
- R7: A falling channel-clock edge never loads data.
- R8: The two channels are independent. Activity on one channel's controls or input never changes the other channel's output or output enable.
- R9: The conflict flag is high exactly when both channels' output-enable vectors are all ones.
- R10: Storage keeps operating while a channel is isolated. A value loaded while the output enable is high appears once the output is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH | Data arriving on port A |
| b_in | input | WIDTH | Data arriving on port B |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ab_le | input | 1 | A-to-B latch enable, high = transparent |
| ab_ck | input | 1 | A-to-B channel clock |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| ba_le | input | 1 | B-to-A latch enable, high = transparent |
| ba_ck | input | 1 | B-to-A channel clock |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| a_out | output | WIDTH | Data driven onto port A by the B-to-A channel |
| a_oe | output | WIDTH | Per-bit drive enable for port A |
| b_out | output | WIDTH | Data driven onto port B by the A-to-B channel |
| b_oe | output | WIDTH | Per-bit drive enable for port B |
| dir_conflict | output | 1 | Both channels drive at once |

## Verification
A corrupt storage register stays hidden while its channel is transparent or isolated. It shows at the output as soon as the latch enable is low and the output enable is low: INPUT_STAGES cycles after those controls settle, or one cycle later after a load edge. A missed or spurious event appears the same way. A lost rising edge leaves the old word on the output. A load on a falling edge or an inhibited edge replaces the word. So every check is made in a held, non-transparent state that a reference model tracks step by step, with one control changed at a time.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

   typedef struct packed {
      logic le;
      logic ce_n;
      logic ck;
      logic oe_n;
   } ctl_t;

   typedef enum logic [1:0] {
      ACT_KEEP  = 2'd0,
      ACT_TRACK = 2'd1,
      ACT_LOAD  = 2'd2
   } store_act_e;

   localparam ctl_t CTL_IDLE = '{le: 1'b0, ce_n: 1'b1, ck: 1'b0, oe_n: 1'b1};

   // Fixed priority: transparency wins, then an enabled rising edge, else hold.
   function automatic store_act_e pick_act(input ctl_t c, input logic rise);
      if (c.le)
         return ACT_TRACK;
      else if (!c.ce_n && rise)
         return ACT_LOAD;
      else
         return ACT_KEEP;
   endfunction

endpackage

// File: rtl/ubt_sampler.sv
module ubt_sampler
   import ubt_pkg::*;
#(
   parameter int WIDTH  = 18,
   parameter int STAGES = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  ctl_t             ctl_i,
   input  logic [WIDTH-1:0] d_i,
   output ctl_t             ctl_o,
   output logic [WIDTH-1:0] d_o
);

   ctl_t [STAGES:0]             ctl_pipe;
   logic [STAGES:0][WIDTH-1:0]  d_pipe;

   assign ctl_pipe[0] = ctl_i;
   assign d_pipe[0]   = d_i;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) begin
            ctl_pipe[s+1] <= CTL_IDLE;
            d_pipe[s+1]   <= '0;
         end else begin
            ctl_pipe[s+1] <= ctl_pipe[s];
            d_pipe[s+1]   <= d_pipe[s];
         end
      end
   end

   assign ctl_o = ctl_pipe[STAGES];
   assign d_o   = d_pipe[STAGES];

endmodule

// File: rtl/ubt_event_det.sv
module ubt_event_det (
   input  logic clk,
   input  logic rst,
   input  logic ck_s,
   input  logic le_s,
   output logic ck_rise,
   output logic le_fall
);

   logic ck_p;
   logic le_p;

   always_ff @(posedge clk) begin
      if (rst) begin
         ck_p <= 1'b0;
         le_p <= 1'b0;
      end else begin
         ck_p <= ck_s;
         le_p <= le_s;
      end
   end

   assign ck_rise = ck_s & ~ck_p;
   assign le_fall = le_p & ~le_s;

endmodule

// File: rtl/ubt_store.sv
module ubt_store
   import ubt_pkg::*;
#(
   parameter int WIDTH = 18
) (
   input  logic             clk,
   input  logic             rst,
   input  store_act_e       act,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else begin
         case (act)
            ACT_TRACK, ACT_LOAD: q <= d;
            default:             q <= q;
         endcase
      end
   end

   // R1: reset empties storage
   p_reset_clear_r1: assert property (@(posedge clk) rst |=> (q == '0));

endmodule

// File: rtl/ubt_channel.sv
module ubt_channel
   import ubt_pkg::*;
#(
   parameter int WIDTH  = 18,
   parameter int STAGES = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  ctl_t             ctl_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] d_o,
   output logic [WIDTH-1:0] oe_o
);

   ctl_t             ctl_s;
   logic [WIDTH-1:0] d_s;
   logic             ck_rise;
   logic             le_fall;
   store_act_e       act;
   logic [WIDTH-1:0] q;

   ubt_sampler #(.WIDTH(WIDTH), .STAGES(STAGES)) u_smp (
      .clk   (clk),
      .rst   (rst),
      .ctl_i (ctl_i),
      .d_i   (d_i),
      .ctl_o (ctl_s),
      .d_o   (d_s)
   );

   ubt_event_det u_evt (
      .clk     (clk),
      .rst     (rst),
      .ck_s    (ctl_s.ck),
      .le_s    (ctl_s.le),
      .ck_rise (ck_rise),
      .le_fall (le_fall)
   );

   assign act = pick_act(ctl_s, ck_rise);

   ubt_store #(.WIDTH(WIDTH)) u_st (
      .clk (clk),
      .rst (rst),
      .act (act),
      .d   (d_s),
      .q   (q)
   );

   assign d_o  = ctl_s.le ? d_s : q;
   assign oe_o = {WIDTH{~ctl_s.oe_n}};

   // R3: transparent storage follows the sampled input
   p_track_r3: assert property (@(posedge clk) disable iff (rst)
      ctl_s.le |=> (q == $past(d_s)));
   // R4: a latch-enable fall with no rising edge freezes storage
   p_latch_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (le_fall && !ck_rise) |=> $stable(q));
   // R5: an enabled rising edge loads the sampled input
   p_load_r5: assert property (@(posedge clk) disable iff (rst)
      (!ctl_s.le && !ctl_s.ce_n && ck_rise) |=> (q == $past(d_s)));
   // R6: inhibited clock keeps storage
   p_inhibit_r6: assert property (@(posedge clk) disable iff (rst)
      (!ctl_s.le && ctl_s.ce_n) |=> $stable(q));
   // R7: without a rising edge, latch mode never changes storage
   p_no_fall_load_r7: assert property (@(posedge clk) disable iff (rst)
      (!ctl_s.le && !ck_rise) |=> $stable(q));

endmodule

// File: rtl/ubt_datapath.sv
module ubt_datapath
   import ubt_pkg::*;
#(
   parameter int WIDTH        = 18,
   parameter int INPUT_STAGES = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             ab_ce_n,
   input  logic             ab_le,
   input  logic             ab_ck,
   input  logic             ab_oe_n,
   input  logic             ba_ce_n,
   input  logic             ba_le,
   input  logic             ba_ck,
   input  logic             ba_oe_n,
   output logic [WIDTH-1:0] a_out,
   output logic [WIDTH-1:0] a_oe,
   output logic [WIDTH-1:0] b_out,
   output logic [WIDTH-1:0] b_oe,
   output logic             dir_conflict
);

   localparam int NCH = 2;

   if (WIDTH < 1) begin : g_bad_width
      $error("ubt_datapath: WIDTH must be at least 1");
   end
   if (INPUT_STAGES < 1 || INPUT_STAGES > 4) begin : g_bad_stages
      $error("ubt_datapath: INPUT_STAGES must lie in 1..4");
   end

   ctl_t [NCH-1:0]             ctl_v;
   logic [NCH-1:0][WIDTH-1:0]  din_v;
   logic [NCH-1:0][WIDTH-1:0]  dout_v;
   logic [NCH-1:0][WIDTH-1:0]  oe_v;

   // channel 0 carries A toward B, channel 1 carries B toward A
   assign ctl_v[0] = '{le: ab_le, ce_n: ab_ce_n, ck: ab_ck, oe_n: ab_oe_n};
   assign ctl_v[1] = '{le: ba_le, ce_n: ba_ce_n, ck: ba_ck, oe_n: ba_oe_n};
   assign din_v[0] = a_in;
   assign din_v[1] = b_in;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      ubt_channel #(.WIDTH(WIDTH), .STAGES(INPUT_STAGES)) u_ch (
         .clk   (clk),
         .rst   (rst),
         .ctl_i (ctl_v[c]),
         .d_i   (din_v[c]),
         .d_o   (dout_v[c]),
         .oe_o  (oe_v[c])
      );
   end

   assign b_out = dout_v[0];
   assign b_oe  = oe_v[0];
   assign a_out = dout_v[1];
   assign a_oe  = oe_v[1];

   assign dir_conflict = (|a_oe) & (|b_oe);

   // R9: a flagged conflict means both ports are fully driven
   p_conflict_r9: assert property (@(posedge clk) disable iff (rst)
      dir_conflict |-> ((a_oe == '1) && (b_oe == '1)));
   // R2: enable vectors are never partial
   p_oe_whole_r2: assert property (@(posedge clk) disable iff (rst)
      ((a_oe == '0) || (a_oe == '1)) && ((b_oe == '0) || (b_oe == '1)));

endmodule

// File: tb/sim_ubt_datapath.sv
module sim_ubt_datapath;

   localparam int W          = 18;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic ab_ce_n = 1'b1, ab_le = 1'b0, ab_ck = 1'b0, ab_oe_n = 1'b1;
   logic ba_ce_n = 1'b1, ba_le = 1'b0, ba_ck = 1'b0, ba_oe_n = 1'b1;
   logic [W-1:0] a_out, a_oe, b_out, b_oe;
   logic         dir_conflict;

   ubt_datapath #(.WIDTH(W), .INPUT_STAGES(1)) u0 (
      .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
      .ab_ce_n(ab_ce_n), .ab_le(ab_le), .ab_ck(ab_ck), .ab_oe_n(ab_oe_n),
      .ba_ce_n(ba_ce_n), .ba_le(ba_le), .ba_ck(ba_ck), .ba_oe_n(ba_oe_n),
      .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
      .dir_conflict(dir_conflict)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 0;

   // reference model, index 0 = A-to-B, 1 = B-to-A
   logic [1:0]   m_le, m_ce_n, m_ck, m_oe_n;
   logic [W-1:0] m_din [2];
   logic [W-1:0] m_store [2];

   task automatic drive();
      ab_le = m_le[0]; ab_ce_n = m_ce_n[0]; ab_ck = m_ck[0]; ab_oe_n = m_oe_n[0]; a_in = m_din[0];
      ba_le = m_le[1]; ba_ce_n = m_ce_n[1]; ba_ck = m_ck[1]; ba_oe_n = m_oe_n[1]; b_in = m_din[1];
   endtask

   task automatic settle();
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [W-1:0] exp_out(int ch);
      return m_le[ch] ? m_din[ch] : m_store[ch];
   endfunction

   function automatic logic [W-1:0] exp_oe(int ch);
      return m_oe_n[ch] ? '0 : '1;
   endfunction

   task automatic check_vec(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_ch(int ch, string req);
      if (ch == 0) begin
         check_vec(req, "b_out", b_out, exp_out(0));
         check_vec(req, "b_oe",  b_oe,  exp_oe(0));
      end else begin
         check_vec(req, "a_out", a_out, exp_out(1));
         check_vec(req, "a_oe",  a_oe,  exp_oe(1));
      end
   endtask

   task automatic check_conflict(string req);
      logic e;
      e = !m_oe_n[0] && !m_oe_n[1];
      n_tests++;
      if (dir_conflict !== e) begin
         n_fail++;
         $display("FAIL %s dir_conflict actual=%b expected=%b", req, dir_conflict, e);
      end
   endtask

   // one control or data change per call, model updated per the requirements
   task automatic apply_op(int ch, int op, logic [W-1:0] val);
      case (op)
         0: begin m_din[ch] = val; if (m_le[ch]) m_store[ch] = val; end
         1: begin m_le[ch] = ~m_le[ch]; if (m_le[ch]) m_store[ch] = m_din[ch]; end
         2: begin
               m_ck[ch] = ~m_ck[ch];
               if (m_ck[ch] && !m_le[ch] && !m_ce_n[ch]) m_store[ch] = m_din[ch];
            end
         3: m_ce_n[ch] = ~m_ce_n[ch];
         default: m_oe_n[ch] = ~m_oe_n[ch];
      endcase
   endtask

   function automatic string req_of(int ch, int op);
      if (op == 4)                       return "R2";
      if (m_le[ch])                      return "R3";
      if (op == 2 && m_ck[ch] && !m_ce_n[ch]) return "R5";
      if (op == 2 && !m_ck[ch])          return "R7";
      if (m_ce_n[ch])                    return "R6";
      return "R4";
   endfunction

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [W-1:0] v1, v2;
      void'($urandom(32'h1D5E_A0C3));
      for (int c = 0; c < 2; c++) begin
         m_le[c] = 0; m_ce_n[c] = 1; m_ck[c] = 0; m_oe_n[c] = 1;
         m_din[c] = '0; m_store[c] = '0;
      end
      drive();
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      settle();
      // R1: outputs isolated and storage empty after reset
      check_ch(0, "R1");
      check_ch(1, "R1");
      m_oe_n = 2'b00;
      m_din[0] = W'($urandom); m_din[1] = W'($urandom);
      drive(); settle();
      check_ch(0, "R1");
      check_ch(1, "R1");
      check_conflict("R9");

      // R10: load while isolated, reveal later
      v1 = W'($urandom) | W'(1);
      m_oe_n[0] = 1'b1; drive(); settle();
      check_ch(0, "R2");
      m_ce_n[0] = 1'b0; m_din[0] = v1; drive(); settle();
      apply_op(0, 2, '0); drive(); settle();
      check_ch(0, "R10");
      m_oe_n[0] = 1'b0; drive(); settle();
      check_vec("R10", "b_out", b_out, v1);

      // R7: falling edge with new data does not load
      v2 = ~v1;
      apply_op(0, 0, v2); drive(); settle();
      apply_op(0, 2, '0); drive(); settle();
      check_vec("R7", "b_out", b_out, v1);

      // R8: other channel toggling leaves channel 0 unchanged
      apply_op(1, 1, '0); drive(); settle();
      apply_op(1, 0, W'($urandom)); drive(); settle();
      check_ch(0, "R8");
      check_ch(1, "R3");

      // R9: conflict clears when one side isolates
      apply_op(1, 4, '0); drive(); settle();
      check_conflict("R9");

      // R4: latch freeze, then data change ignored
      apply_op(0, 1, '0); drive(); settle();
      apply_op(0, 0, v1); drive(); settle();
      check_ch(0, "R3");
      apply_op(0, 1, '0); drive(); settle();
      apply_op(0, 0, v2); drive(); settle();
      check_vec("R4", "b_out", b_out, v1);

      // constrained random: one change per channel per step
      for (int i = 0; i < 400; i++) begin
         int op0, op1;
         op0 = $urandom_range(0, 4);
         op1 = $urandom_range(0, 4);
         apply_op(0, op0, W'($urandom));
         apply_op(1, op1, W'($urandom));
         drive(); settle();
         check_ch(0, req_of(0, op0));
         check_ch(1, (op0 != op1) ? "R8" : req_of(1, op1));
         check_conflict("R9");
      end
      summary();
   end

endmodule